// File: doc/BRIEF.md
# Single-Block SHA-1 Coprocessor

This block is a slave on a 32-bit bus. It computes the SHA-1 hash of one 512-bit block. The host writes sixteen 32-bit words into an internal message buffer and then raises the start input. The engine runs one SHA-1 compression over the buffer. It always begins from the standard initial chaining values. While it runs, busy is high. When busy drops, the five 32-bit digest words can be read at fixed addresses.

The block does not pad the message and does not chain blocks. The host must supply a block that is already padded. Read data is registered. Bus writes to the buffer are refused while a computation runs. This keeps the message the engine sees the same from the first round to the last.

Top module: `sha1_coproc`

## Requirements
- R1: After reset, busy is 0, rdata is 0, and the five digest words read as 0.
- R2: The bus is decoded only when cs_n is 0. A write to addresses 0..15 (wr_n 0) stores the word. A read (wr_n 1) loads the addressed word into rdata at the next clock edge. With no read, rdata holds its value.
- R3: Reads of addresses 21..31 return 0.
- R4: When busy is 0, start at a clock edge sets busy at that edge. Busy then stays high for exactly 81 cycles.
- R5: After busy falls, addresses 16..20 return digest words A..E. These equal the SHA-1 compression of buffer words 0..15, with the first message byte in bits 31:24 of word 0, starting from the standard initial values. The digest words change only when a computation ends.
- R6: A start while busy is 1 has no effect. Busy still falls 81 cycles after the accepted start, and the digest is unchanged.
- R7: Writes while busy is 1 are discarded.
- R8: A write made in the same cycle as an accepted start is stored. It is also part of the block that gets hashed.
- R9: With cs_n at 1, writes are ignored and rdata holds its value.
- R10: A computation leaves the message buffer contents unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe (1 = read) |
| addr | input | 5 | Word address: 0..15 buffer, 16..20 digest A..E |
| wdata | input | 32 | Write data |
| start | input | 1 | Start a compression |
| rdata | output | 32 | Registered read data |
| busy | output | 1 | Computation in progress |

## Verification
A buffer write and an accepted start can happen in the same cycle. The engine must then take the new word into its schedule rather than the stale one. The bench drives a write to one buffer word and the start pulse on the same negative edge. It then compares the digest with a bench model built from the buffer that includes that word, and reads the word back. A second overlap is a start or a write that arrives while busy is high. Both are judged by the length of busy, by the digest, and by reading the buffer back afterwards.

// File: rtl/sha1_coproc.sv
module sha1_coproc (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_n,
  input  logic        wr_n,
  input  logic [4:0]  addr,
  input  logic [31:0] wdata,
  input  logic        start,
  output logic [31:0] rdata,
  output logic        busy
);
  localparam logic [31:0] IV0 = 32'h67452301;
  localparam logic [31:0] IV1 = 32'hEFCDAB89;
  localparam logic [31:0] IV2 = 32'h98BADCFE;
  localparam logic [31:0] IV3 = 32'h10325476;
  localparam logic [31:0] IV4 = 32'hC3D2E1F0;
  localparam int LAST = 80;

  logic [15:0][31:0] mem;
  logic [15:0][31:0] sched;
  logic [4:0][31:0]  res;
  logic [31:0] va, vb, vc, vd, ve;
  logic [6:0]  cnt;
  logic [31:0] fval, kval, tmp, nxt;

  wire wr_ok = !cs_n && !wr_n && !addr[4] && !busy;
  wire rd_ok = !cs_n && wr_n;
  wire go    = start && !busy;

  always_comb begin
    if (cnt < 7'd20) begin
      fval = (vb & vc) | (~vb & vd);
      kval = 32'h5A827999;
    end else if (cnt < 7'd40) begin
      fval = vb ^ vc ^ vd;
      kval = 32'h6ED9EBA1;
    end else if (cnt < 7'd60) begin
      fval = (vb & vc) | (vb & vd) | (vc & vd);
      kval = 32'h8F1BBCDC;
    end else begin
      fval = vb ^ vc ^ vd;
      kval = 32'hCA62C1D6;
    end
  end

  assign tmp = {va[26:0], va[31:27]} + fval + ve + kval + sched[0];
  wire [31:0] mix = sched[13] ^ sched[8] ^ sched[2] ^ sched[0];
  assign nxt = {mix[30:0], mix[31]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem <= '0;
    end else if (wr_ok) begin
      mem[addr[3:0]] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt   <= '0;
      sched <= '0;
      res   <= '0;
      {va, vb, vc, vd, ve} <= '0;
    end else if (go) begin
      busy <= 1'b1;
      cnt  <= '0;
      {va, vb, vc, vd, ve} <= {IV0, IV1, IV2, IV3, IV4};
      for (int i = 0; i < 16; i++)
        sched[i] <= (wr_ok && addr[3:0] == i[3:0]) ? wdata : mem[i];
    end else if (busy) begin
      if (cnt == LAST[6:0]) begin
        busy   <= 1'b0;
        res[0] <= va + IV0;
        res[1] <= vb + IV1;
        res[2] <= vc + IV2;
        res[3] <= vd + IV3;
        res[4] <= ve + IV4;
      end else begin
        cnt <= cnt + 7'd1;
        ve  <= vd;
        vd  <= vc;
        vc  <= {vb[1:0], vb[31:2]};
        vb  <= va;
        va  <= tmp;
        for (int i = 0; i < 15; i++)
          sched[i] <= sched[i+1];
        sched[15] <= nxt;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rdata <= '0;
    else if (rd_ok) begin
      if (!addr[4])
        rdata <= mem[addr[3:0]];
      else if (addr <= 5'd20)
        rdata <= res[addr[2:0]];
      else
        rdata <= '0;
    end
  end
endmodule

// File: rtl/sha1_coproc_chk.sv
module sha1_coproc_chk (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              wr_n,
  input logic [4:0]        addr,
  input logic              start,
  input logic              busy,
  input logic [31:0]       rdata,
  input logic [15:0][31:0] mem,
  input logic [4:0][31:0]  res
);
  logic [7:0] bcnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bcnt <= '0;
    else if (busy) bcnt <= bcnt + 8'd1;
    else bcnt <= '0;
  end

  p_busy_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  p_busy_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bcnt < 8'd80) |=> busy);
  p_busy_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bcnt == 8'd80) |=> !busy);
  p_no_write_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mem));
  p_hi_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && wr_n && addr > 5'd20) |=> rdata == 32'h0);
  p_rd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(!cs_n && wr_n) |=> $stable(rdata));
  p_res_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(res));
endmodule

bind sha1_coproc sha1_coproc_chk i_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .addr(addr),
  .start(start), .busy(busy), .rdata(rdata), .mem(mem), .res(res)
);

// File: tb/test_sha1_coproc.sv
module test_sha1_coproc;
  logic clk = 0, rst_n = 0, cs_n = 1, wr_n = 1, start = 0;
  logic [4:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic busy;
  int errors = 0, checks = 0;
  logic [31:0] blk [16];
  logic [31:0] dig [5];

  always #10 clk = ~clk;

  sha1_coproc i_sha1_coproc (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n),
    .addr(addr), .wdata(wdata), .start(start), .rdata(rdata), .busy(busy));

  function automatic logic [31:0] rl(input logic [31:0] x, input int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  task automatic model();
    logic [31:0] w [80];
    logic [31:0] a, b, c, d, e, f, k, t;
    for (int i = 0; i < 16; i++) w[i] = blk[i];
    for (int i = 16; i < 80; i++) w[i] = rl(w[i-3] ^ w[i-8] ^ w[i-14] ^ w[i-16], 1);
    a = 32'h67452301; b = 32'hEFCDAB89; c = 32'h98BADCFE; d = 32'h10325476; e = 32'hC3D2E1F0;
    for (int i = 0; i < 80; i++) begin
      if (i < 20) begin f = (b & c) | (~b & d); k = 32'h5A827999; end
      else if (i < 40) begin f = b ^ c ^ d; k = 32'h6ED9EBA1; end
      else if (i < 60) begin f = (b & c) | (b & d) | (c & d); k = 32'h8F1BBCDC; end
      else begin f = b ^ c ^ d; k = 32'hCA62C1D6; end
      t = rl(a, 5) + f + e + k + w[i];
      e = d; d = c; c = rl(b, 30); b = a; a = t;
    end
    dig[0] = a + 32'h67452301; dig[1] = b + 32'hEFCDAB89; dig[2] = c + 32'h98BADCFE;
    dig[3] = d + 32'h10325476; dig[4] = e + 32'hC3D2E1F0;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); cs_n = 0; wr_n = 0; addr = a; wdata = d;
    @(negedge clk); cs_n = 1; wr_n = 1;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); cs_n = 0; wr_n = 1; addr = a;
    @(negedge clk); cs_n = 1; d = rdata;
  endtask

  task automatic load_blk();
    for (int i = 0; i < 16; i++) wr(5'(i), blk[i]);
  endtask

  task automatic run(input int extra_at, output int len);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    len = 0;
    while (busy) begin
      len++;
      if (len == extra_at) start = 1; else start = 0;
      @(negedge clk);
    end
    start = 0;
  endtask

  task automatic check_digest(input string req);
    logic [31:0] v;
    model();
    for (int i = 0; i < 5; i++) begin
      rd(5'(16 + i), v);
      chk(req, v, dig[i]);
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 busy", {31'b0, busy}, 32'h0);
    chk("R1 rdata", rdata, 32'h0);
    for (int i = 0; i < 5; i++) begin rd(5'(16 + i), v); chk("R1 digest", v, 32'h0); end
  endtask

  task automatic t_rw();
    logic [31:0] v;
    for (int i = 0; i < 16; i++) blk[i] = 32'h1000_0001 * (i + 3) ^ 32'hA5A5_0000;
    load_blk();
    for (int i = 0; i < 16; i++) begin rd(5'(i), v); chk("R2 readback", v, blk[i]); end
    @(negedge clk); @(negedge clk);
    chk("R2 rdata hold", rdata, blk[15]);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    rd(5'd21, v); chk("R3 addr21", v, 32'h0);
    rd(5'd31, v); chk("R3 addr31", v, 32'h0);
  endtask

  task automatic t_abc();
    int len;
    blk[0] = 32'h61626380;
    for (int i = 1; i < 15; i++) blk[i] = 32'h0;
    blk[15] = 32'h00000018;
    load_blk();
    run(0, len);
    chk("R4 busy length", 32'(len), 32'd81);
    check_digest("R5 model abc");
    dig = '{32'hA9993E36, 32'h4706816A, 32'hBA3E2571, 32'h7850C26C, 32'h9CD0D89D};
    begin
      logic [31:0] v;
      rd(5'd16, v); chk("R5 known A", v, dig[0]);
      rd(5'd20, v); chk("R5 known E", v, dig[4]);
    end
  endtask

  task automatic t_pattern(input logic [31:0] seed);
    int len;
    for (int i = 0; i < 16; i++) blk[i] = seed ^ rl(32'h9E3779B9 * (i + 1), i + 1);
    load_blk();
    run(0, len);
    chk("R4 busy length", 32'(len), 32'd81);
    check_digest("R5 pattern");
  endtask

  task automatic t_start_busy();
    int len;
    blk[2] = 32'hDEADBEEF;
    wr(5'd2, blk[2]);
    run(30, len);
    chk("R6 busy length", 32'(len), 32'd81);
    chk("R6 not busy", {31'b0, busy}, 32'h0);
    check_digest("R6 digest");
  endtask

  task automatic t_write_busy();
    logic [31:0] v;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0; cs_n = 0; wr_n = 0; addr = 5'd7; wdata = 32'h0BAD_0BAD;
    @(negedge clk); cs_n = 1; wr_n = 1;
    while (busy) @(negedge clk);
    rd(5'd7, v); chk("R7 discarded", v, blk[7]);
    check_digest("R7 digest");
  endtask

  task automatic t_coincident();
    logic [31:0] v;
    blk[3] = 32'h3C3C_5A5A;
    @(negedge clk); cs_n = 0; wr_n = 0; addr = 5'd3; wdata = blk[3]; start = 1;
    @(negedge clk); cs_n = 1; wr_n = 1; start = 0;
    chk("R8 busy", {31'b0, busy}, 32'h1);
    while (busy) @(negedge clk);
    rd(5'd3, v); chk("R8 stored", v, blk[3]);
    check_digest("R8 digest");
  endtask

  task automatic t_cs_high();
    logic [31:0] v;
    rd(5'd5, v);
    @(negedge clk); cs_n = 1; wr_n = 0; addr = 5'd5; wdata = ~blk[5];
    @(negedge clk); wr_n = 1; addr = 5'd16;
    @(negedge clk);
    chk("R9 rdata hold", rdata, blk[5]);
    rd(5'd5, v); chk("R9 write ignored", v, blk[5]);
  endtask

  task automatic t_buffer_kept();
    logic [31:0] v;
    for (int i = 0; i < 16; i++) begin rd(5'(i), v); chk("R10 buffer", v, blk[i]); end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_rw();
    t_unmapped();
    t_abc();
    t_pattern(32'h0);
    t_pattern(32'hFFFF_FFFF);
    t_start_busy();
    t_write_busy();
    t_coincident();
    t_cs_high();
    t_buffer_kept();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R4 watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule